// File: doc/BRIEF.md
# Random Byte Register Peripheral

This block sits on a simple synchronous host bus and hands out random bytes one at a time. An external entropy source offers bytes over an 8-bit valid/ready port; the block holds a single byte, raises an availability flag, and waits for the host to collect it. The host polls the control/status word, and once the flag is set it reads the data word. That read returns the byte and empties the holder, which lets the next byte in.

The generator runs only while two conditions hold together: an enable bit in the control/status word is set, and a separate 8-bit mode register holds the run code 0x02. While either condition fails, the holder is emptied and the entropy port refuses bytes. A 4-bit prescaler field is stored and read back, but it has no effect inside the block. Every host access covers a whole word. Read data appears on the edge that samples the read strobe.

Top module: `rbyte_periph`

## Requirements
- R1: After reset, control/status, data and mode all read 0, `bus_rd_data` is 0 and `ent_ready` is 0.
- R2: The generator is active only when control/status bit 0 is 1 and the mode register equals 0x02. With any other mode value, or with bit 0 at 0, `ent_ready` stays 0 and no byte is taken.
- R3: While the generator is inactive, the availability flag (control/status bit 1) reads 0 and any held byte is discarded. The byte does not come back when the generator becomes active again.
- R4: `ent_ready` is 1 exactly when the generator is active and the flag is 0. On an edge where both `ent_valid` and `ent_ready` are 1, `ent_byte` is stored and the flag is set.
- R5: A read of the data word (byte offset 0x04) while active with the flag at 1 returns the byte in bits 7:0 with the upper bits 0, and clears both the flag and the stored byte. Any other data read returns 0 and changes nothing.
- R6: Control/status (offset 0x00) has the enable at bit 0, the flag at bit 1 and the prescaler at bits 5:2, with bits 31:6 reading 0. A write updates the enable and the prescaler. Bit 1 of the write data is ignored, so the flag keeps its value.
- R7: Writes to the data word are ignored. The held byte and the flag are unchanged.
- R8: The mode register (offset 0x08) is an 8-bit read/write register, and bits 31:8 read 0.
- R9: The block decodes the word index from address bits 11:2. Any offset from 0x0C to 0xFFC reads 0, and writes there change no register.
- R10: `bus_rd_data` is loaded on the clock edge that samples `bus_rd_en`, with register values from before that edge. It is 0 after any edge on which `bus_rd_en` was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 12 | Byte address of the access (word aligned) |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data |
| ent_valid | input | 1 | Entropy source offers a byte |
| ent_byte | input | 8 | Offered byte |
| ent_ready | output | 1 | Block takes the offered byte on this edge |

## Verification
The bench checks that a byte offered while the holder is full is not taken. A design that ignored ready would overwrite the pending byte. It checks that a second data read returns 0, which catches a read that is not destructive. It checks that switching the mode away from 0x02 and back loses the held byte, which exposes a design that only masks the flag instead of clearing it. It also writes the control word with bit 1 both set and clear, and writes the data word and unmapped offsets. A design that let those writes reach the flag, the byte or the mode would show the wrong status value or the wrong returned byte.

// File: rtl/rbyte_pkg.sv
package rbyte_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_MODE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [7:0] RUN_CODE_DEF = 8'h02;

endpackage

// File: rtl/rbyte_rst_sync.sv
module rbyte_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/rbyte_ctrl.sv
module rbyte_ctrl
  import rbyte_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PRESC_W  = 4,
  parameter int unsigned MODE_W   = 8,
  parameter logic [7:0]  RUN_CODE = RUN_CODE_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output reg_sel_e           sel,
  output logic               en_q,
  output logic [PRESC_W-1:0] presc_q,
  output logic [MODE_W-1:0]  mode_q,
  output logic               active,
  output logic               data_rd
);

  localparam int unsigned IDX_W    = ADDR_W - 2;
  localparam int unsigned PRESC_LO = 2;
  localparam int unsigned PRESC_HI = PRESC_LO + PRESC_W - 1;

  logic [IDX_W-1:0]   word_idx;
  logic               ctrl_we;
  logic               mode_we;
  logic               en_d;
  logic [PRESC_W-1:0] presc_d;
  logic [MODE_W-1:0]  mode_d;

  assign word_idx = addr[ADDR_W-1:2];

  always_comb begin
    case (word_idx)
      IDX_W'(0): sel = SEL_CTRL;
      IDX_W'(1): sel = SEL_DATA;
      IDX_W'(2): sel = SEL_MODE;
      default:   sel = SEL_NONE;
    endcase
  end

  assign ctrl_we = wr_en && (sel == SEL_CTRL);
  assign mode_we = wr_en && (sel == SEL_MODE);
  assign data_rd = rd_en && (sel == SEL_DATA);

  // next-state
  always_comb begin
    en_d    = en_q;
    presc_d = presc_q;
    mode_d  = mode_q;
    if (ctrl_we) begin
      en_d    = wr_data[0];
      presc_d = wr_data[PRESC_HI:PRESC_LO];
    end
    if (mode_we) begin
      mode_d = wr_data[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      presc_q <= '0;
      mode_q  <= '0;
    end else begin
      en_q    <= en_d;
      presc_q <= presc_d;
      mode_q  <= mode_d;
    end
  end

  assign active = en_q && (mode_q == MODE_W'(RUN_CODE));

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], wr_data[DATA_W-1:MODE_W], wr_data[1]};

  // R8
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_q == $past(wr_data[MODE_W-1:0])));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_NONE) |=> ($stable(mode_q) && $stable(en_q) && $stable(presc_q)));

endmodule

// File: rtl/rbyte_slot.sv
module rbyte_slot #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              data_rd,
  input  logic              ent_valid,
  input  logic [BYTE_W-1:0] ent_byte,
  output logic              ent_ready,
  output logic              full_q,
  output logic [BYTE_W-1:0] byte_q,
  output logic [BYTE_W-1:0] rd_byte
);

  logic              full_d;
  logic [BYTE_W-1:0] byte_d;
  logic              take;

  assign ent_ready = active && !full_q;
  assign take      = data_rd && active && full_q;
  assign rd_byte   = take ? byte_q : '0;

  // next-state
  always_comb begin
    full_d = full_q;
    byte_d = byte_q;
    if (!active) begin
      full_d = 1'b0;
      byte_d = '0;
    end else if (take) begin
      full_d = 1'b0;
      byte_d = '0;
    end else if (ent_ready && ent_valid) begin
      full_d = 1'b1;
      byte_d = ent_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      byte_q <= '0;
    end else begin
      full_q <= full_d;
      byte_q <= byte_d;
    end
  end

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_ready) |=> (full_q && byte_q == $past(ent_byte)));

  // R3
  idle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!full_q && byte_q == '0));

  // R5
  take_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && active && full_q) |=> (!full_q && byte_q == '0));

endmodule

// File: rtl/rbyte_periph.sv
module rbyte_periph
  import rbyte_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PRESC_W  = 4,
  parameter int unsigned MODE_W   = 8,
  parameter logic [7:0]  RUN_CODE = RUN_CODE_DEF,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rd_data,
  input  logic              ent_valid,
  input  logic [BYTE_W-1:0] ent_byte,
  output logic              ent_ready
);

  localparam int unsigned STAT_W = 2 + PRESC_W;

  logic               rst_n;
  reg_sel_e           sel;
  logic               en_q;
  logic [PRESC_W-1:0] presc_q;
  logic [MODE_W-1:0]  mode_q;
  logic               active;
  logic               data_rd;
  logic               full_q;
  logic [BYTE_W-1:0]  byte_q;
  logic [BYTE_W-1:0]  rd_byte;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rd_data_d;
  logic [DATA_W-1:0]  rd_data_q;

  rbyte_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  rbyte_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PRESC_W  (PRESC_W),
    .MODE_W   (MODE_W),
    .RUN_CODE (RUN_CODE)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .wr_en   (bus_wr_en),
    .wr_data (bus_wr_data),
    .rd_en   (bus_rd_en),
    .sel     (sel),
    .en_q    (en_q),
    .presc_q (presc_q),
    .mode_q  (mode_q),
    .active  (active),
    .data_rd (data_rd)
  );

  rbyte_slot #(.BYTE_W(BYTE_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .data_rd   (data_rd),
    .ent_valid (ent_valid),
    .ent_byte  (ent_byte),
    .ent_ready (ent_ready),
    .full_q    (full_q),
    .byte_q    (byte_q),
    .rd_byte   (rd_byte)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = DATA_W'({presc_q, full_q && active, en_q});
      SEL_DATA: rd_mux = DATA_W'(rd_byte);
      SEL_MODE: rd_mux = DATA_W'(mode_q);
      default:  rd_mux = '0;
    endcase
  end

  assign rd_data_d = bus_rd_en ? rd_mux : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_q <= '0;
    else        rd_data_q <= rd_data_d;
  end

  assign bus_rd_data = rd_data_q;

  logic unused_width;
  assign unused_width = (STAT_W == 0) ^ (^byte_q);

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> (bus_rd_data == '0));

  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && sel == SEL_MODE && bus_wr_data[MODE_W-1:0] != MODE_W'(RUN_CODE))
      |=> !ent_ready);

endmodule

// File: tb/rbyte_periph_bench.sv
module rbyte_periph_bench;

  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_DATA = 12'h004;
  localparam logic [11:0] A_MODE = 12'h008;

  logic        clk = 1'b0;
  logic        arst_n;
  logic [11:0] bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wr_data;
  logic        bus_rd_en;
  logic [31:0] bus_rd_data;
  logic        ent_valid;
  logic [7:0]  ent_byte;
  logic        ent_ready;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rbyte_periph u_rbyte_periph (
    .clk         (clk),
    .arst_n      (arst_n),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_en   (bus_rd_en),
    .bus_rd_data (bus_rd_data),
    .ent_valid   (ent_valid),
    .ent_byte    (ent_byte),
    .ent_ready   (ent_ready)
  );

  task automatic compare(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wr_data = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rd_data;
  endtask

  task automatic offer(input logic [7:0] b);
    @(negedge clk);
    ent_valid = 1'b1; ent_byte = b;
    @(negedge clk);
    ent_valid = 1'b0; ent_byte = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    compare("R1 rd_data", bus_rd_data, 32'h0);
    compare("R1 ent_ready", {31'b0, ent_ready}, 32'h0);
    bus_read(A_CTRL, v); compare("R1 ctrl", v, 32'h0);
    bus_read(A_DATA, v); compare("R1 data", v, 32'h0);
    bus_read(A_MODE, v); compare("R1 mode", v, 32'h0);
  endtask

  task automatic t_gating;
    logic [31:0] v;
    bus_write(A_CTRL, 32'h1);
    @(negedge clk);
    compare("R2 ready off with mode 0", {31'b0, ent_ready}, 32'h0);
    offer(8'h77);
    bus_read(A_CTRL, v); compare("R2 no byte taken", v, 32'h1);
    bus_write(A_MODE, 32'hFFFF_FF02);
    bus_read(A_MODE, v); compare("R8 mode readback", v, 32'h02);
    @(negedge clk);
    compare("R4 ready when active", {31'b0, ent_ready}, 32'h1);
    bus_write(A_CTRL, 32'h0);
    @(negedge clk);
    compare("R2 ready off with enable 0", {31'b0, ent_ready}, 32'h0);
  endtask

  task automatic t_load_take;
    logic [31:0] v;
    bus_write(A_CTRL, 32'h3D);
    offer(8'hA5);
    compare("R4 ready drops when full", {31'b0, ent_ready}, 32'h0);
    bus_read(A_CTRL, v); compare("R6 status full", v, 32'h3F);
    offer(8'h3C);
    bus_read(A_DATA, v); compare("R5 first read", v, 32'hA5);
    bus_read(A_CTRL, v); compare("R5 flag cleared", v, 32'h3D);
    bus_read(A_DATA, v); compare("R5 second read", v, 32'h0);
  endtask

  task automatic t_writes_ignored;
    logic [31:0] v;
    offer(8'h11);
    bus_write(A_DATA, 32'hFFFF_FFFF);
    bus_write(A_CTRL, 32'h0000_0005);
    bus_read(A_CTRL, v); compare("R6 flag kept on ctrl write", v, 32'h07);
    bus_write(A_CTRL, 32'hFFFF_FFC1);
    bus_read(A_CTRL, v); compare("R6 upper bits ignored", v, 32'h03);
    bus_read(A_DATA, v); compare("R7 byte unchanged", v, 32'h11);
    bus_write(A_CTRL, 32'h0000_0003);
    bus_read(A_CTRL, v); compare("R6 flag not set by write", v, 32'h01);
  endtask

  task automatic t_discard;
    logic [31:0] v;
    offer(8'h5A);
    bus_write(A_MODE, 32'h03);
    bus_read(A_CTRL, v); compare("R3 flag 0 when inactive", v, 32'h01);
    bus_read(A_DATA, v); compare("R3 data 0 when inactive", v, 32'h0);
    bus_write(A_MODE, 32'h02);
    bus_read(A_CTRL, v); compare("R3 byte not restored", v, 32'h01);
    bus_read(A_DATA, v); compare("R3 data still empty", v, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    bus_write(12'h00C, 32'hFFFF_FFFF);
    bus_write(12'hFFC, 32'hFFFF_FFFF);
    bus_read(12'h00C, v); compare("R9 read 0x00C", v, 32'h0);
    bus_read(12'h808, v); compare("R9 read 0x808", v, 32'h0);
    bus_read(A_MODE, v); compare("R9 mode untouched", v, 32'h02);
    bus_read(A_CTRL, v); compare("R9 ctrl untouched", v, 32'h01);
  endtask

  task automatic t_read_timing;
    logic [31:0] v;
    offer(8'hC3);
    @(negedge clk);
    bus_addr = A_DATA; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_addr = A_CTRL;
    v = bus_rd_data;
    compare("R10 data on sampling edge", v, 32'hC3);
    @(negedge clk);
    bus_rd_en = 1'b0;
    compare("R10 status after take", bus_rd_data, 32'h01);
    @(negedge clk);
    compare("R10 zero without strobe", bus_rd_data, 32'h0);
  endtask

  initial begin
    arst_n = 1'b0; bus_addr = '0; bus_wr_en = 1'b0; bus_wr_data = '0;
    bus_rd_en = 1'b0; ent_valid = 1'b0; ent_byte = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gating();
    t_load_take();
    t_writes_ignored();
    t_discard();
    t_unmapped();
    t_read_timing();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule